// File: doc/BRIEF.md
# Chunk-Interleaved Image Selector

This block sits on a byte stream that carries several independent images woven together in equal, fixed-size chunks: a chunk of the first image, then a chunk of the second, and so on through the last image, after which the rotation starts again with the first. It passes through only the bytes of one chosen image and drops every other chunk. The dropped bytes are consumed without producing any output.

Both sides are valid/ready byte streams and the path is combinational, so no byte is buffered inside. Two configuration inputs set the block's behaviour. One sets how many images are interleaved. The other selects which image to keep, counted from one. A restart input returns the position tracking to the first byte of the combined stream so that a fresh pass can begin.

Position is kept as a byte offset inside the current chunk together with an image-slot counter, so no division is needed. A running count of delivered bytes is available at a port for checking.

Top module: `chunk_demux`

## Requirements
- R1: The combined stream is split into chunks of CHUNK_BYTES bytes. The chunk with index c (counted from zero) belongs to image (c mod numImages) + 1, so image 1 owns the first chunk.
- R2: An accepted byte at combined index k appears on outData unchanged, with outValid high, exactly when (k / CHUNK_BYTES) mod numImages equals imageSel - 1. outValid is low when inValid is low.
- R3: While the current byte belongs to the selected image, inReady follows outReady. A byte that is presented but not taken stays pending and is not counted as consumed.
- R4: While the current byte belongs to another image, inReady is high regardless of outReady, outValid is low, and the byte is discarded.
- R5: The combined index advances on every accepted byte, whether it is passed or dropped. A cycle with restart high returns the index to zero, and inReady is low in that cycle.
- R6: cfgError is high when imageSel is 0 or greater than numImages. While it is high, outValid and inReady are low and the stream position does not move.
- R7: passCount counts the bytes handed to the output (outValid and outReady both high). Reset and restart clear it to zero, and it wraps at its width.
- R8: After reset, outValid is low, passCount is 0 and the position is combined index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| restart | input | 1 | Return to the start of the combined stream |
| numImages | input | IMG_W | Number of interleaved images |
| imageSel | input | IMG_W | Image to keep, counted from one |
| inValid | input | 1 | Input byte valid |
| inData | input | DATA_W | Input byte |
| inReady | output | 1 | Input byte accepted this cycle if valid |
| outValid | output | 1 | Output byte valid |
| outData | output | DATA_W | Output byte |
| outReady | input | 1 | Downstream can take a byte |
| cfgError | output | 1 | Selector is zero or beyond the image count |
| passCount | output | CNT_W | Bytes delivered since reset or restart |

## Verification
The bench uses a short chunk length and sweeps every image count up to four, with every valid selector for each count. Each run streams more than two full rotations of bytes whose values encode their index. This separates off-by-one errors in chunk boundaries from errors in the slot wrap and in selector decoding. Back-pressure is applied on selected bytes to show that they are held, and on dropped bytes to show that they still drain. Separate runs use a restart in the middle of a chunk and both kinds of invalid selector, which shows that the position is reset in one case and frozen in the other.

// File: rtl/chunk_demux_pkg.sv
package chunk_demux_pkg;
  typedef struct packed {
    logic advance;
    logic pass;
    logic clear;
  } demux_strobe_t;
endpackage

// File: rtl/chunk_demux_dp.sv
module chunk_demux_dp
  import chunk_demux_pkg::*;
#(
  parameter int CHUNK_BYTES = 288,
  parameter int MAX_IMAGES  = 8,
  parameter int CNT_W       = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  demux_strobe_t       strb,
  input  logic [IMG_W-1:0]    numImages,
  output logic [IMG_W-1:0]    slot,
  output logic [CNT_W-1:0]    passCount
);
  localparam int IMG_W = $clog2(MAX_IMAGES + 1);
  localparam int OFF_W = (CHUNK_BYTES > 1) ? $clog2(CHUNK_BYTES) : 1;
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(CHUNK_BYTES - 1);

  logic [OFF_W-1:0] offset;
  logic             chunkEnd;
  logic             slotLast;

  assign chunkEnd = (offset == OFF_LAST);
  assign slotLast = ({1'b0, slot} + 1'b1) >= {1'b0, numImages};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offset <= '0;
      slot   <= '0;
    end else if (strb.clear) begin
      offset <= '0;
      slot   <= '0;
    end else if (strb.advance) begin
      if (chunkEnd) begin
        offset <= '0;
        slot   <= slotLast ? '0 : slot + 1'b1;
      end else begin
        offset <= offset + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            passCount <= '0;
    else if (strb.clear)  passCount <= '0;
    else if (strb.pass)   passCount <= passCount + 1'b1;
  end

  // R1: offset stays inside a chunk and a full chunk moves to the next slot
  p_offset_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    offset <= OFF_LAST);
  p_chunk_wrap_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.clear && chunkEnd) |=> (offset == '0));
  // R5: restart returns the position to the start
  p_clear_pos_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (offset == '0 && slot == '0 && passCount == '0));
endmodule

// File: rtl/chunk_demux_ctrl.sv
module chunk_demux_ctrl
  import chunk_demux_pkg::*;
#(
  parameter int MAX_IMAGES = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic [IMG_W-1:0] numImages,
  input  logic [IMG_W-1:0] imageSel,
  input  logic [IMG_W-1:0] slot,
  input  logic             inValid,
  input  logic             outReady,
  output logic             inReady,
  output logic             outValid,
  output logic             cfgError,
  output demux_strobe_t    strb
);
  localparam int IMG_W = $clog2(MAX_IMAGES + 1);

  logic selMatch;

  assign cfgError = (imageSel == '0) || (imageSel > numImages);
  assign selMatch = (imageSel != '0) && (slot == imageSel - 1'b1);

  always_comb begin
    inReady  = 1'b0;
    outValid = 1'b0;
    if (!cfgError && !restart) begin
      inReady  = selMatch ? outReady : 1'b1;
      outValid = inValid && selMatch;
    end
  end

  always_comb begin
    strb.clear   = restart;
    strb.advance = inValid && inReady;
    strb.pass    = inValid && inReady && selMatch;
  end

  // R3: a selected byte waiting on the output is not consumed
  p_hold_selected_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);
  // R4: dropping never raises outValid
  p_drop_silent_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.pass) |-> !outValid);
endmodule

// File: rtl/chunk_demux.sv
module chunk_demux
  import chunk_demux_pkg::*;
#(
  parameter int CHUNK_BYTES = 288,
  parameter int MAX_IMAGES  = 8,
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 16,
  localparam int IMG_W      = $clog2(MAX_IMAGES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              restart,
  input  logic [IMG_W-1:0]  numImages,
  input  logic [IMG_W-1:0]  imageSel,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  input  logic              outReady,
  output logic              cfgError,
  output logic [CNT_W-1:0]  passCount
);
  demux_strobe_t    strb;
  logic [IMG_W-1:0] slot;

  assign outData = inData;

  chunk_demux_ctrl #(.MAX_IMAGES(MAX_IMAGES)) ctrl (
    .clk(clk), .rstN(rstN), .restart(restart),
    .numImages(numImages), .imageSel(imageSel), .slot(slot),
    .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .cfgError(cfgError),
    .strb(strb)
  );

  chunk_demux_dp #(.CHUNK_BYTES(CHUNK_BYTES), .MAX_IMAGES(MAX_IMAGES), .CNT_W(CNT_W)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .numImages(numImages),
    .slot(slot), .passCount(passCount)
  );

  // R6: a bad selector blocks both sides
  p_cfg_block_r6: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> (!outValid && !inReady));
  // R7: every handover bumps the delivered count by one
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !restart) |=> (passCount == CNT_W'($past(passCount) + 1'b1)));
  // R5: no byte is taken during restart
  p_restart_stall_r5: assert property (@(posedge clk) disable iff (!rstN)
    restart |-> !inReady);
endmodule

// File: tb/chunk_demux_test.sv
`timescale 1ns/1ps
module chunk_demux_test;
  localparam int CH    = 3;
  localparam int MAXI  = 4;
  localparam int IMG_W = $clog2(MAXI + 1);
  localparam int CNT_W = 16;

  logic clk = 0;
  logic rstN = 0;
  logic restart = 0;
  logic [IMG_W-1:0] numImages = 2;
  logic [IMG_W-1:0] imageSel = 1;
  logic inValid = 0;
  logic [7:0] inData = 0;
  logic inReady, outValid, outReady, cfgError;
  logic [7:0] outData;
  logic [CNT_W-1:0] passCount;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  chunk_demux #(.CHUNK_BYTES(CH), .MAX_IMAGES(MAXI), .DATA_W(8), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .restart(restart), .numImages(numImages), .imageSel(imageSel),
    .inValid(inValid), .inData(inData), .inReady(inReady), .outValid(outValid),
    .outData(outData), .outReady(outReady), .cfgError(cfgError), .passCount(passCount)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doRestart();
    @(negedge clk);
    restart = 1; inValid = 0;
    #1 chk(inReady == 0, "R5 restart stall", int'(inReady), 0);
    @(negedge clk);
    restart = 0;
  endtask

  // R1/R2/R3/R4: send byte with combined index k; returns 1 if it belongs to the selected image
  task automatic sendByte(input int k, input int n, input int s, output bit wasSel);
    bit sel;
    byte unsigned d;
    sel = ((k / CH) % n) == (s - 1);
    d = byte'(k * 37 + n * 5 + s);
    wasSel = sel;
    @(negedge clk);
    inValid = 1; inData = d;
    if (sel && (k % 2 == 1)) begin
      outReady = 0;
      #1;
      chk(inReady == 0, "R3 held while blocked", int'(inReady), 0);
      chk(outValid == 1, "R3 pending valid", int'(outValid), 1);
      @(negedge clk);
    end
    outReady = sel ? 1'b1 : 1'(k % 2);
    #1;
    if (sel) begin
      chk(outValid == 1 && inReady == 1, "R2 selected passes", int'({outValid, inReady}), 3);
      chk(outData == d, "R2 data", int'(outData), int'(d));
    end else begin
      chk(outValid == 0 && inReady == 1, "R4 dropped", int'({outValid, inReady}), 1);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ws;
    int expPass;
    outReady = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(outValid == 0, "R8 reset outValid", int'(outValid), 0);
    chk(passCount == 0, "R8 reset passCount", int'(passCount), 0);
    rstN = 1;
    // R8: index 0 belongs to image 1
    @(negedge clk);
    inValid = 1; inData = 8'h5a; outReady = 1;
    #1 chk(outValid == 1 && outData == 8'h5a, "R8 starts at index 0", int'(outValid), 1);
    inValid = 0;
    #1 chk(outValid == 0, "R2 idle no output", int'(outValid), 0);

    // R1/R2: sweep every count and selector
    for (int n = 1; n <= MAXI; n++) begin
      for (int s = 1; s <= n; s++) begin
        numImages = IMG_W'(n); imageSel = IMG_W'(s);
        doRestart();
        expPass = 0;
        for (int k = 0; k < n * CH * 2 + 2; k++) begin
          sendByte(k, n, s, ws);
          if (ws) expPass++;
        end
        @(negedge clk);
        inValid = 0;
        #1 chk(passCount == CNT_W'(expPass), "R7 delivered count", int'(passCount), expPass);
        chk(cfgError == 0, "R6 valid selector", int'(cfgError), 0);
      end
    end

    // R5: restart in the middle of a chunk
    numImages = 3; imageSel = 2;
    doRestart();
    for (int k = 0; k < 4; k++) sendByte(k, 3, 2, ws);
    doRestart();
    #1 chk(passCount == 0, "R7 restart clears count", int'(passCount), 0);
    sendByte(0, 3, 2, ws);
    sendByte(1, 3, 2, ws);
    sendByte(2, 3, 2, ws);
    sendByte(3, 3, 2, ws);

    // R6: invalid selectors
    @(negedge clk);
    inValid = 1; outReady = 1; imageSel = 0;
    #1 chk(cfgError == 1 && outValid == 0 && inReady == 0, "R6 selector zero",
           int'({cfgError, outValid, inReady}), 4);
    imageSel = 4;
    #1 chk(cfgError == 1 && outValid == 0 && inReady == 0, "R6 selector above count",
           int'({cfgError, outValid, inReady}), 4);
    // R6: position frozen while blocked
    inValid = 0;
    doRestart();
    @(negedge clk);
    imageSel = 0; inValid = 1; inData = 8'h11;
    repeat (3) @(negedge clk);
    imageSel = 1;
    #1 chk(outValid == 1 && outData == 8'h11, "R6 position held", int'(outValid), 1);
    chk(passCount == 0, "R6 nothing delivered", int'(passCount), 0);
    @(negedge clk);
    inValid = 0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule